// File: doc/BRIEF.md
# Prioritized interrupt level encoder

This block turns seven interrupt request inputs into a single prioritized request for a processor core. Software gives each input its own priority level from 1 to 7, plus an enable bit. Levels 1 to 6 follow the input level. They stay pending while the input is high, and the current processor mask can hold them off. Level 7 is different: it is taken on a rising edge, stored in a per-input latch, and no mask value can block it.

Each cycle the block reports the highest pending level that the mask lets through, together with a valid strobe. When the core acknowledges a valid request, the block does three things:

- It records the serviced level.
- It raises the mask to that level.
- If the serviced level was 7, it clears the level-7 latches.

A new level-7 edge that arrives while a level-7 service is running requests again at once. Turning a level-7 input off and back on while it is high counts as such an edge.

Top module: `irq_level_encoder`

## Requirements
- R1: After reset, req_valid is 0, req_level is 0, mask_out is 7 and ack_level is 0. All enables are cleared and all input levels are 0.
- R2: An enabled input mapped to a level from 1 to 6 is pending for as long as it stays high and its level is above the mask. A change on the input shows on req_level at the third rising edge after it is applied, not earlier.
- R3: A request at levels 1 to 6 whose level is less than or equal to mask_out is never reported. When it is valid, req_level is either 7 or strictly greater than mask_out.
- R4: A level-7 input requests on a rising edge, even when mask_out is 7. An input that simply stays high after its acknowledge does not request again.
- R5: During level-7 service with the mask at 7, every new rising edge on a level-7 input requests at level 7 again. A disable followed by an enable of a level-7 input that is high counts as a rising edge.
- R6: If ack is high while req_valid is 1, then at that same edge mask_out and ack_level both take the value of req_level. If ack is high while req_valid is 0, nothing changes.
- R7: req_level is the highest pending unmasked level. Several inputs at the winning level produce one request at that level, and that request stays while any one of them remains pending.
- R8: A write with cfg_we sets the level (cfg_level) and enable (cfg_enable) of input cfg_sel, and any input can take any level. A disabled input, or one with level 0, makes no request.
- R9: A write with mask_we loads mask_out from mask_wdata at that edge, and requests are filtered against the new mask from the same edge. An acknowledge in the same cycle takes precedence over the write.
- R10: A captured level-7 request stays pending after its input falls, until an acknowledge at level 7 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 7 | Asynchronous active-high request inputs |
| cfg_we | input | 1 | Write strobe for one input's configuration |
| cfg_sel | input | 3 | Index of the input being configured |
| cfg_level | input | 3 | Priority level to assign (0 = unassigned) |
| cfg_enable | input | 1 | Enable bit to assign |
| mask_we | input | 1 | Write strobe for the processor mask |
| mask_wdata | input | 3 | New mask value |
| ack | input | 1 | Core acknowledges the current request |
| req_level | output | 3 | Highest pending unmasked level (registered) |
| req_valid | output | 1 | A request is being presented (registered) |
| mask_out | output | 3 | Current priority mask |
| ack_level | output | 3 | Level of the most recently acknowledged request |

## Verification
Each result has a fixed latency:

| Stimulus | Result due |
|---|---|
| Change on an input pin | Third rising edge after it is applied (two synchronizer stages plus the output register) |
| Configuration write | One edge after the write edge |
| Mask write or acknowledge | The write or acknowledge edge itself |

The driver pushes each expected value into a queue tagged with the exact cycle number when it becomes due. For pin changes it also pushes the unchanged value for the cycle before, which shows the result does not appear early. The monitor samples shortly after each falling edge and compares only the entries that fall due in that cycle. An entry whose cycle has already passed counts as a failure.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = '0;
  localparam lvl_t LVL_NMI  = '1;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pin_cfg.sv
module irq_pin_cfg
  import irq_enc_pkg::*;
#(
  parameter int NUM_PINS = 7,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_sel,
  input  lvl_t                wr_level,
  input  logic                wr_enable,
  output logic [NUM_PINS-1:0] pin_en,
  output lvl_t [NUM_PINS-1:0] pin_lvl
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_en[i]  <= 1'b0;
        pin_lvl[i] <= LVL_NONE;
      end else if (wr_en && (wr_sel == IDX_W'(i))) begin
        pin_en[i]  <= wr_enable;
        pin_lvl[i] <= wr_level;
      end
    end
  end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_PINS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] active,
  input  logic [NUM_PINS-1:0] is_nmi,
  input  logic                clr,
  output logic [NUM_PINS-1:0] latch_nxt,
  output logic [NUM_PINS-1:0] latch_q
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise;

  assign rise      = active & ~prev_q & is_nmi;
  assign latch_nxt = (latch_q & {NUM_PINS{~clr}}) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= active;
      latch_q <= latch_nxt;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (latch_q[i] && !clr) |=> latch_q[i]); // R10
    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
      (active[i] && is_nmi[i] && !prev_q[i]) |=> latch_q[i]); // R5
  end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq_enc_pkg::*;
#(
  parameter int NUM_PINS = 7
) (
  input  logic [NUM_PINS-1:0] active,
  input  lvl_t [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] nmi_pend,
  input  lvl_t                mask,
  output lvl_t                best
);
  logic [NUM_PINS-1:0] pend;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pend
    always_comb begin
      if (pin_lvl[i] == LVL_NMI) pend[i] = nmi_pend[i];
      else pend[i] = active[i] && (pin_lvl[i] != LVL_NONE) && (pin_lvl[i] > mask);
    end
  end

  always_comb begin
    best = LVL_NONE;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pend[i] && (pin_lvl[i] > best)) best = pin_lvl[i];
    end
  end
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irq_enc_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_sel,
  input  logic [LVL_W-1:0]    cfg_level,
  input  logic                cfg_enable,
  input  logic                mask_we,
  input  logic [LVL_W-1:0]    mask_wdata,
  input  logic                ack,
  output logic [LVL_W-1:0]    req_level,
  output logic                req_valid,
  output logic [LVL_W-1:0]    mask_out,
  output logic [LVL_W-1:0]    ack_level
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_en;
  lvl_t [NUM_PINS-1:0] pin_lvl;
  logic [NUM_PINS-1:0] active;
  logic [NUM_PINS-1:0] is_nmi;
  logic [NUM_PINS-1:0] latch_nxt;
  logic [NUM_PINS-1:0] latch_q;
  lvl_t                mask_q, mask_nxt, ack_q, req_q, best;
  logic                vld_q, do_ack, nmi_clr;

  irq_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(irq_in), .sync_out(pin_sync)
  );

  irq_pin_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_level(cfg_level), .wr_enable(cfg_enable),
    .pin_en(pin_en), .pin_lvl(pin_lvl)
  );

  assign active = pin_sync & pin_en;
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_nmi
    assign is_nmi[i] = (pin_lvl[i] == LVL_NMI);
  end

  assign do_ack  = ack && vld_q;
  assign nmi_clr = do_ack && (req_q == LVL_NMI);

  irq_edge_capture #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .active(active), .is_nmi(is_nmi), .clr(nmi_clr),
    .latch_nxt(latch_nxt), .latch_q(latch_q)
  );

  always_comb begin
    if (do_ack)       mask_nxt = req_q;
    else if (mask_we) mask_nxt = mask_wdata;
    else              mask_nxt = mask_q;
  end

  irq_prio_encoder #(.NUM_PINS(NUM_PINS)) u_enc (
    .active(active), .pin_lvl(pin_lvl), .nmi_pend(latch_nxt),
    .mask(mask_nxt), .best(best)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= LVL_NMI;
      ack_q  <= LVL_NONE;
      req_q  <= LVL_NONE;
      vld_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      if (do_ack) ack_q <= req_q;
      req_q  <= best;
      vld_q  <= (best != LVL_NONE);
    end
  end

  assign req_level = req_q;
  assign req_valid = vld_q;
  assign mask_out  = mask_q;
  assign ack_level = ack_q;

  AST_ACK_RAISES_MASK: assert property (@(posedge clk) disable iff (rst)
    (ack && req_valid) |=> (mask_out == $past(req_level)) && (ack_level == $past(req_level))); // R6
  AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (ack && !req_valid && !mask_we) |=> $stable(mask_out) && $stable(ack_level)); // R6
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_level != LVL_NMI) |-> (req_level > mask_out)); // R3
  AST_VALID_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    req_valid == (req_level != LVL_NONE)); // R7
endmodule

// File: tb/irq_level_encoder_test.sv
module irq_level_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [2:0] cfg_level = '0;
  logic       cfg_enable = 1'b0;
  logic       mask_we = 1'b0;
  logic [2:0] mask_wdata = '0;
  logic       ack = 1'b0;
  logic [2:0] req_level, mask_out, ack_level;
  logic       req_valid;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [2:0] lvl;
    logic       vld;
    logic [2:0] msk;
    logic [2:0] ackl;
    string      tag;
  } exp_t;
  exp_t sb[$];

  irq_level_encoder uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_level(cfg_level), .cfg_enable(cfg_enable), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .ack(ack), .req_level(req_level),
    .req_valid(req_valid), .mask_out(mask_out), .ack_level(ack_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dly, logic [2:0] l, logic v, logic [2:0] m,
                           logic [2:0] a, string tag);
    exp_t e;
    e.due = cyc + dly; e.lvl = l; e.vld = v; e.msk = m; e.ackl = a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(int sel, int lvl, bit en);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_level = 3'(lvl); cfg_enable = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic mask_write(int v);
    mask_we = 1'b1; mask_wdata = 3'(v);
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (e.due < cyc) begin
          errors++;
          $display("FAIL %s: check due at cycle %0d was missed (now %0d)", e.tag, e.due, cyc);
        end else if (req_level !== e.lvl || req_valid !== e.vld ||
                     mask_out !== e.msk || ack_level !== e.ackl) begin
          errors++;
          $display("FAIL %s at cycle %0d: got lvl=%0d vld=%0d mask=%0d ack=%0d, expected lvl=%0d vld=%0d mask=%0d ack=%0d",
                   e.tag, cyc, req_level, req_valid, mask_out, ack_level,
                   e.lvl, e.vld, e.msk, e.ackl);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got running expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    expect_at(0, 0, 0, 7, 0, "R1 reset state");
    wait_cyc(1);

    cfg_write(0, 3, 1);
    cfg_write(1, 5, 1);
    irq_in[0] = 1'b1;
    expect_at(3, 0, 0, 7, 0, "R3 level 3 blocked by mask 7");
    wait_cyc(4);

    mask_write(0);
    expect_at(0, 3, 1, 0, 0, "R9 mask write unblocks level 3");
    wait_cyc(1);

    irq_in[1] = 1'b1;
    expect_at(2, 3, 1, 0, 0, "R2 not before third edge");
    expect_at(3, 5, 1, 0, 0, "R7 higher level wins");
    wait_cyc(4);

    do_ack();
    expect_at(0, 0, 0, 5, 5, "R6 ack raises mask to 5");
    wait_cyc(2);
    do_ack();
    expect_at(0, 0, 0, 5, 5, "R6 ack without request ignored");
    wait_cyc(1);

    irq_in[1] = 1'b0;
    wait_cyc(4);
    mask_write(2);
    expect_at(0, 3, 1, 2, 5, "R9 mask 2 lets level 3 through");
    wait_cyc(1);

    cfg_write(2, 3, 1);
    irq_in[2] = 1'b1;
    wait_cyc(4);
    expect_at(0, 3, 1, 2, 5, "R7 shared level one request");
    wait_cyc(1);
    irq_in[0] = 1'b0;
    expect_at(3, 3, 1, 2, 5, "R7 request held by other pin");
    wait_cyc(4);

    cfg_write(3, 6, 0);
    cfg_write(4, 0, 1);
    irq_in[3] = 1'b1;
    irq_in[4] = 1'b1;
    wait_cyc(4);
    expect_at(0, 3, 1, 2, 5, "R8 disabled and unassigned pins silent");
    wait_cyc(1);
    cfg_write(3, 6, 1);
    expect_at(1, 6, 1, 2, 5, "R8 enabled pin at level 6");
    wait_cyc(2);

    mask_write(7);
    expect_at(0, 0, 0, 7, 5, "R3 mask 7 blocks levels 1 to 6");
    wait_cyc(1);
    cfg_write(5, 7, 1);
    wait_cyc(2);
    irq_in[5] = 1'b1;
    expect_at(2, 0, 0, 7, 5, "R4 edge not seen before third edge");
    expect_at(3, 7, 1, 7, 5, "R4 level 7 passes mask 7");
    wait_cyc(4);

    irq_in[5] = 1'b0;
    wait_cyc(4);
    expect_at(0, 7, 1, 7, 5, "R10 latch holds after input falls");
    wait_cyc(1);

    do_ack();
    expect_at(0, 0, 0, 7, 7, "R6 ack at level 7 clears request");
    wait_cyc(2);

    irq_in[5] = 1'b1;
    expect_at(3, 7, 1, 7, 7, "R5 new edge during level 7 service");
    wait_cyc(4);
    do_ack();
    expect_at(0, 0, 0, 7, 7, "R6 second level 7 ack");
    wait_cyc(4);
    expect_at(0, 0, 0, 7, 7, "R4 held-high input does not re-request");
    wait_cyc(1);

    cfg_write(5, 7, 0);
    cfg_write(5, 7, 1);
    expect_at(1, 7, 1, 7, 7, "R5 re-enable counts as edge");
    wait_cyc(2);
    do_ack();
    expect_at(0, 0, 0, 7, 7, "R6 ack after re-enable edge");
    wait_cyc(2);

    mask_write(5);
    expect_at(0, 6, 1, 5, 7, "R9 mask 5 lets level 6 through");
    wait_cyc(3);

    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d entries left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule